// File: doc/BRIEF.md
# Thermometer-to-Binary Flash Decoder

This block turns the latched comparator word of an 8-bit flash quantizer into a straight binary sample code. Each comparator bit is 1 when the sampled input lies above its own step of the reference ladder, so a well-formed word is a run of ones from the lowest threshold up to the signal level, with zeros above it. The decoder captures that word on a rising clock edge, cleans isolated disagreeing bits with a three-input majority vote, marks the single point where the ones stop, and encodes that point into the output code.

Comparators near the decision level can resolve late or wrongly and leave a single flipped bit in the word. The encoding path is built so that such a bubble moves the result by at most one code and can never turn a mid-range sample into a false full-scale or zero-scale code. The transition point is encoded through a reflected Gray code before conversion to binary, so that two adjacent marked positions merge into one of the two neighbouring codes.

The data path is a stream with a valid flag on each side and no ready signal. The pipeline is fixed at three stages and never stalls: a word may be presented on every clock, and each word flagged valid comes out exactly three clocks later with its valid flag. Downstream logic cannot apply back-pressure and must take every valid output on the cycle it appears.

Top module: `thermo_decoder`

## Requirements
- R1: While reset is asserted, and until the first valid word has passed through the pipeline, out_valid is 0 and out_code is 0.
- R2: out_valid is high exactly three rising edges after in_valid was sampled high; a new word is accepted on every edge and no back-pressure exists.
- R3: For a clean word with c ones in bits 0 to c-1 (bit 0 is the lowest threshold) and zeros above, out_code equals c as an unsigned binary number.
- R4: An all-zero word gives out_code 8'h00 and an all-ones word gives out_code 8'hFF, so underrange and overrange inputs stay pinned at the ends.
- R5: A word with exactly its 128 lowest bits set (the zero-difference input) gives out_code 8'h80.
- R6: A clean word of level c with one bit flipped at index i, where i is at most c-3 or at least c+2, still gives out_code equal to c.
- R7: A clean word of level c with one bit flipped at index i, where i lies from c-2 to c+1, gives out_code within one code of c.
- R8: A single flipped bit never yields 8'hFF unless c is at least 254, and never yields 8'h00 unless c is at most 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock; the comparator word is taken on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Marks in_therm as a sample to be decoded |
| in_therm | input | 255 | Comparator word, bit k set when the input is above threshold k |
| out_valid | output | 1 | Marks out_code as a decoded sample |
| out_code | output | 8 | Decoded sample level in straight binary |

## Verification
Every clean level from 0 to 255 is sent once, which separates a correct count of ones from an off-by-one or mis-ordered encoder and covers both pinned ends and mid-scale. Each level is then sent again with a single flipped bit at each index from two below to one above the transition, which tells a bounded one-code error apart from a Gray merge that goes wrong or a jump to an end code. Random bubbles far from the transition show whether the majority vote really removes them, and a burst of back-to-back words with idle gaps exposes any error in the three-cycle alignment of the valid flag.

// File: rtl/thermdec_pkg.sv
package thermdec_pkg;

  localparam int unsigned DEF_NBITS = 8;

  function automatic int unsigned to_gray(input int unsigned v);
    return v ^ (v >> 1);
  endfunction

endpackage

// File: rtl/therm_capture.sv
module therm_capture #(
  parameter int NLEV = 255
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            d_valid,
  input  logic [NLEV-1:0] d_word,
  output logic            q_valid,
  output logic [NLEV-1:0] q_word
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_word  <= '0;
    end else begin
      q_valid <= d_valid;
      q_word  <= d_word;
    end
  end

endmodule

// File: rtl/bubble_edge_finder.sv
module bubble_edge_finder #(
  parameter int NLEV = 255
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            d_valid,
  input  logic [NLEV-1:0] d_word,
  output logic            q_valid,
  output logic [NLEV:0]   q_hot
);

  localparam int NPOS = NLEV + 1;

  // padded word: a fixed 1 below the lowest threshold, a fixed 0 above the top
  logic [NPOS:0] padded;
  logic [NPOS:0] voted;
  logic [NLEV:0] hot;

  assign padded = {1'b0, d_word, 1'b1};

  assign voted[0]    = 1'b1;
  assign voted[NPOS] = 1'b0;

  genvar gi;
  generate
    for (gi = 1; gi <= NLEV; gi++) begin : g_vote
      assign voted[gi] = (padded[gi-1] & padded[gi])
                       | (padded[gi-1] & padded[gi+1])
                       | (padded[gi]   & padded[gi+1]);
    end
    for (gi = 0; gi <= NLEV; gi++) begin : g_edge
      assign hot[gi] = voted[gi] & ~voted[gi+1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_hot   <= '0;
    end else begin
      q_valid <= d_valid;
      q_hot   <= hot;
    end
  end

endmodule

// File: rtl/hot_gray_encoder.sv
module hot_gray_encoder #(
  parameter int NBITS = 8,
  localparam int NPOS = 2 ** NBITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             d_valid,
  input  logic [NPOS-1:0]  d_hot,
  output logic             q_valid,
  output logic [NBITS-1:0] q_code
);

  logic [NBITS-1:0] gray;
  logic [NBITS-1:0] bin;

  // OR of the Gray codes of all marked positions: two neighbours differ
  // in one bit, so the OR equals one of them
  always_comb begin
    gray = '0;
    for (int p = 0; p < NPOS; p++) begin
      if (d_hot[p]) gray = gray | NBITS'(thermdec_pkg::to_gray(p));
    end
  end

  always_comb begin
    bin[NBITS-1] = gray[NBITS-1];
    for (int j = NBITS - 2; j >= 0; j--) begin
      bin[j] = bin[j+1] ^ gray[j];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_code  <= '0;
    end else begin
      q_valid <= d_valid;
      q_code  <= bin;
    end
  end

endmodule

// File: rtl/thermo_decoder.sv
module thermo_decoder #(
  parameter int NBITS = thermdec_pkg::DEF_NBITS,
  localparam int NLEV = 2 ** NBITS - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [NLEV-1:0]  in_therm,
  output logic             out_valid,
  output logic [NBITS-1:0] out_code
);

  logic            cap_valid;
  logic [NLEV-1:0] cap_word;
  logic            hot_valid;
  logic [NLEV:0]   hot_word;

  therm_capture #(.NLEV(NLEV)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_valid (in_valid),
    .d_word  (in_therm),
    .q_valid (cap_valid),
    .q_word  (cap_word)
  );

  bubble_edge_finder #(.NLEV(NLEV)) u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_valid (cap_valid),
    .d_word  (cap_word),
    .q_valid (hot_valid),
    .q_hot   (hot_word)
  );

  hot_gray_encoder #(.NBITS(NBITS)) u_enc (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_valid (hot_valid),
    .d_hot   (hot_word),
    .q_valid (out_valid),
    .q_code  (out_code)
  );

endmodule

// File: rtl/thermo_decoder_chk.sv
module thermo_decoder_chk #(
  parameter int NBITS = 8,
  localparam int NLEV = 2 ** NBITS - 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [NLEV-1:0]  in_therm,
  input logic             out_valid,
  input logic [NBITS-1:0] out_code
);

  localparam int HALF = 2 ** (NBITS - 1);
  localparam logic [NLEV-1:0] MID_WORD = {{(NLEV - HALF){1'b0}}, {HALF{1'b1}}};
  localparam logic [NLEV-1:0] UNIT = {{(NLEV - 1){1'b0}}, 1'b1};

  logic [1:0]       since_rst;
  logic             clean_in;
  logic [NBITS-1:0] ones_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  always_comb begin
    clean_in = in_valid && ((in_therm & (in_therm + UNIT)) == '0);
    ones_in  = NBITS'($countones(in_therm));
  end

  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst != 2'd3) |-> (!out_valid && out_code == '0));

  a_r2_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  a_r3_clean_count: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3 && $past(clean_in, 3)) |-> (out_code == $past(ones_in, 3)));

  a_r4_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3 && $past(in_valid && in_therm == '1, 3)) |-> (out_code == '1));

  a_r4_all_zeros: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3 && $past(in_valid && in_therm == '0, 3)) |-> (out_code == '0));

  a_r5_midscale: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3 && $past(in_valid && in_therm == MID_WORD, 3))
      |-> (out_code == NBITS'(HALF)));

endmodule

bind thermo_decoder thermo_decoder_chk #(.NBITS(NBITS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_therm  (in_therm),
  .out_valid (out_valid),
  .out_code  (out_code)
);

// File: tb/sim_thermo_decoder.sv
module sim_thermo_decoder;

  localparam int NB = 8;
  localparam int NL = 255;

  typedef struct {
    int    exp;
    int    tol;
    string tag;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [NL-1:0] in_therm = '0;
  logic          out_valid;
  logic [NB-1:0] out_code;

  int    checks = 0;
  int    errors = 0;
  bit    finished = 1'b0;
  item_t sb[$];

  always #4 clk = ~clk;

  thermo_decoder #(.NBITS(NB)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_therm  (in_therm),
    .out_valid (out_valid),
    .out_code  (out_code)
  );

  function automatic logic [NL-1:0] level_word(input int c);
    logic [NL-1:0] w;
    for (int i = 0; i < NL; i++) w[i] = (i < c);
    return w;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send(input logic [NL-1:0] w, input int exp, input int tol, input string tag);
    item_t it;
    @(negedge clk);
    in_valid = 1'b1;
    in_therm = w;
    it.exp = exp;
    it.tol = tol;
    it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_therm = '0;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R2 unexpected output", int'(out_code), -1);
      end else begin
        item_t it;
        int got;
        int diff;
        it = sb.pop_front();
        got = int'(out_code);
        diff = (got > it.exp) ? got - it.exp : it.exp - got;
        check(diff <= it.tol, it.tag, got, it.exp);
        if (it.tol > 0) begin
          check(!(got == 255 && it.exp < 254) && !(got == 0 && it.exp > 1),
                "R8 false end code", got, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    check(!out_valid && out_code == '0, "R1 in reset", int'(out_code), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!out_valid && out_code == '0, "R1 after release", int'(out_valid), 0);

    // R2: latency of a single word
    send(level_word(77), 77, 0, "R2 latency word");
    lat = 0;
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      if (out_valid && lat == 0) lat = k;
    end
    check(lat == 3, "R2 latency", lat, 3);

    // R4, R5 directed
    send('0, 0, 0, "R4 all zeros");
    send('1, 255, 0, "R4 all ones");
    send(level_word(128), 128, 0, "R5 midscale");
    idle(2);

    // R3: every clean level, with occasional idle gaps
    for (int c = 0; c <= 255; c++) begin
      send(level_word(c), c, 0, "R3 clean level");
      if (c % 37 == 0) idle(1);
    end
    idle(4);

    // R7, R8: single bubble near the transition
    for (int c = 0; c <= 255; c++) begin
      for (int d = -2; d <= 1; d++) begin
        int i;
        logic [NL-1:0] w;
        i = c + d;
        if (i >= 0 && i < NL) begin
          w = level_word(c);
          w[i] = ~w[i];
          send(w, c, 1, "R7 near bubble");
        end
      end
    end
    idle(4);

    // R6: single bubble far from the transition
    for (int n = 0; n < 400; n++) begin
      int c;
      int i;
      logic [NL-1:0] w;
      c = int'($urandom_range(0, 255));
      i = int'($urandom_range(0, NL - 1));
      if (i <= c - 3 || i >= c + 2) begin
        w = level_word(c);
        w[i] = ~w[i];
        send(w, c, 0, "R6 far bubble");
      end
    end
    idle(6);

    check(sb.size() == 0, "R2 all words returned", sb.size(), 0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule